// File: doc/BRIEF.md
# Operand Fetch and Effective Address Sequencer

This block resolves the operand of an 8-bit processor instruction. A start pulse brings in a mode code, the address of the first operand byte, and the two index registers. The block then reads one, two or three bytes through a byte-wide read port. It returns the operand byte and, for modes that name a memory location, a 16-bit effective address. It also returns the program counter that follows the operand bytes. Executing the instruction, stores and extra cycles for page crossing are the job of the surrounding core.

Mode codes (mode_i): 0 immediate, 1 relative, 2 zero page, 3 zero page + X, 4 zero page + Y, 5 absolute, 6 absolute + X, 7 absolute + Y, 8 indexed indirect (X added before the pointer fetch), 9 indirect indexed (Y added after the pointer fetch). Codes 10 to 15 are undefined. pc_i is the address of the first operand byte, which is the address that follows the opcode.

The read port carries one request at a time. rd_req_o is a one-cycle pulse with rd_addr_o valid in that cycle. The reply arrives on rd_valid_i with rd_data_i in any later cycle.

Top module: `addr_mode_seq`

## Requirements
- R1: After reset, done_o, err_o and rd_req_o are low.
- R2: Modes 0 and 1 read exactly one byte, at pc_i. They return it on operand_o with is_addr_o low and pc_next_o = pc_i + 1.
- R3: In mode 1, ea_o is the branch target: pc_i + 1 plus the operand taken as a signed 8-bit value, modulo 65536.
- R4: Modes 2, 3 and 4 read one byte at pc_i. ea_o = {8'h00, (byte + index) mod 256}, with index 0, X or Y. is_addr_o is high and pc_next_o = pc_i + 1.
- R5: Modes 5, 6 and 7 read the low byte at pc_i and then the high byte at pc_i + 1 (mod 65536). ea_o = {high, low} + index (0, X or Y) mod 65536, and pc_next_o = pc_i + 2.
- R6: Mode 8 reads the operand byte b at pc_i. It then reads the pointer low byte at {8'h00, (b+X) mod 256} and the high byte at {8'h00, (b+X+1) mod 256}. ea_o is the pointer, and pc_next_o = pc_i + 1.
- R7: Mode 9 reads b at pc_i. It then reads the pointer low byte at {8'h00, b} and the high byte at {8'h00, (b+1) mod 256}. ea_o = pointer + Y mod 65536, and pc_next_o = pc_i + 1.
- R8: rd_req_o lasts one cycle. No new request is issued until rd_valid_i has answered the previous one.
- R9: done_o pulses once per accepted start when results are ready. A start with an undefined mode code gives done_o in the next cycle with err_o high and no read. err_o is never high without done_o.
- R10: A start in the cycle of done_o is accepted. A start while reads are in progress is ignored and does not disturb the running sequence.
- R11: rd_valid_i with no read outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin resolving an operand |
| mode_i | input | 4 | Mode code |
| pc_i | input | 16 | Address of first operand byte |
| x_i | input | 8 | X index |
| y_i | input | 8 | Y index |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | 16 | Read address |
| rd_valid_i | input | 1 | Read reply valid |
| rd_data_i | input | 8 | Read reply byte |
| done_o | output | 1 | Result ready pulse |
| err_o | output | 1 | Undefined mode, valid with done_o |
| is_addr_o | output | 1 | ea_o is an operand address |
| operand_o | output | 8 | First operand byte |
| ea_o | output | 16 | Effective address or branch target |
| pc_next_o | output | 16 | Program counter after the operand |

## Verification
Two events can land in the same cycle: the done pulse of one operand and the start of the next. The bench launches every sweep step in the very cycle where it sees done_o, and then judges the second result in full, reads included. A second overlap is a start strobe arriving while a read reply is pending. The bench drives one with a different mode and address in the first waiting cycle of many runs, and expects the read sequence and the results of the running sequence to be unchanged. A stray read reply is also injected on the start edge. Each result is compared against an arithmetic model over modes, index values, operand bytes at the zero-page edges, and program counters at the top of memory.

// File: rtl/aseq_pkg.sv
package aseq_pkg;
  typedef enum logic [3:0] {
    M_IMM  = 4'd0,
    M_REL  = 4'd1,
    M_ZP   = 4'd2,
    M_ZPX  = 4'd3,
    M_ZPY  = 4'd4,
    M_ABS  = 4'd5,
    M_ABSX = 4'd6,
    M_ABSY = 4'd7,
    M_INDX = 4'd8,
    M_INDY = 4'd9
  } amode_e;

  typedef enum logic [1:0] {IDX_NONE, IDX_X, IDX_Y} idx_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_FIN} st_e;

  typedef struct packed {
    logic       legal;
    logic [1:0] last_step;
    logic       ptr;
    logic       zp;
    logic       rel;
    logic       is_addr;
    logic       wide_pc;
    idx_e       pre;
    idx_e       post;
  } attr_t;

  localparam int unsigned NSLOT  = 3;
  localparam int unsigned STEP_W = 2;
  localparam int unsigned NMODE  = 10;

  function automatic logic mode_legal(logic [3:0] m);
    return 32'(m) < NMODE;
  endfunction
endpackage

// File: rtl/aseq_mode_dec.sv
module aseq_mode_dec
  import aseq_pkg::*;
(
  input  logic [3:0] mode_i,
  output attr_t      attr_o
);
  always_comb begin
    attr_o       = '0;
    attr_o.pre   = IDX_NONE;
    attr_o.post  = IDX_NONE;
    attr_o.legal = 1'b1;
    case (amode_e'(mode_i))
      M_IMM: ;
      M_REL: attr_o.rel = 1'b1;
      M_ZP, M_ZPX, M_ZPY: begin
        attr_o.zp      = 1'b1;
        attr_o.is_addr = 1'b1;
        if (amode_e'(mode_i) == M_ZPX) attr_o.post = IDX_X;
        if (amode_e'(mode_i) == M_ZPY) attr_o.post = IDX_Y;
      end
      M_ABS, M_ABSX, M_ABSY: begin
        attr_o.last_step = 2'd1;
        attr_o.wide_pc   = 1'b1;
        attr_o.is_addr   = 1'b1;
        if (amode_e'(mode_i) == M_ABSX) attr_o.post = IDX_X;
        if (amode_e'(mode_i) == M_ABSY) attr_o.post = IDX_Y;
      end
      M_INDX: begin
        attr_o.last_step = 2'd2;
        attr_o.ptr       = 1'b1;
        attr_o.is_addr   = 1'b1;
        attr_o.pre       = IDX_X;
      end
      M_INDY: begin
        attr_o.last_step = 2'd2;
        attr_o.ptr       = 1'b1;
        attr_o.is_addr   = 1'b1;
        attr_o.post      = IDX_Y;
      end
      default: attr_o.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/aseq_ctl.sv
module aseq_ctl
  import aseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              legal_i,
  input  logic [STEP_W-1:0] last_i,
  input  logic              rd_valid_i,
  output logic              rd_req_o,
  output logic              done_o,
  output logic              accept_o,
  output logic              cap_o,
  output logic [STEP_W-1:0] step_o
);
  st_e               state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    accept_o = 1'b0;
    case (state_q)
      ST_IDLE, ST_FIN: begin
        if (start_i) begin
          accept_o = 1'b1;
          step_d   = '0;
          state_d  = legal_i ? ST_REQ : ST_FIN;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_REQ:  state_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_valid_i) begin
          if (step_q == last_i) state_d = ST_FIN;
          else begin
            step_d  = step_q + 1'b1;
            state_d = ST_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign rd_req_o = (state_q == ST_REQ);
  assign done_o   = (state_q == ST_FIN);
  assign cap_o    = (state_q == ST_WAIT) && rd_valid_i;
  assign step_o   = step_q;
endmodule

// File: rtl/aseq_dp.sv
module aseq_dp
  import aseq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [3:0]        mode_i,
  input  logic [2*DW-1:0]   pc_i,
  input  logic [DW-1:0]     x_i,
  input  logic [DW-1:0]     y_i,
  input  logic              cap_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [DW-1:0]     rd_data_i,
  output attr_t             attr_o,
  output logic [2*DW-1:0]   rd_addr_o,
  output logic [DW-1:0]     operand_o,
  output logic [2*DW-1:0]   ea_o,
  output logic [2*DW-1:0]   pc_next_o
);
  localparam int unsigned AW = 2 * DW;
  localparam logic [DW-1:0] ZERO_PG = '0;

  logic [3:0]    mode_q;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] x_q, y_q;
  logic [DW-1:0] byte_q [NSLOT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      pc_q   <= '0;
      x_q    <= '0;
      y_q    <= '0;
    end else if (accept_i) begin
      mode_q <= mode_i;
      pc_q   <= pc_i;
      x_q    <= x_i;
      y_q    <= y_i;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q[s] <= '0;
      else if (cap_i && step_i == STEP_W'(s)) byte_q[s] <= rd_data_i;
    end
  end

  aseq_mode_dec u_dec (.mode_i(mode_q), .attr_o(attr_o));

  function automatic logic [DW-1:0] pick(idx_e sel, logic [DW-1:0] xv, logic [DW-1:0] yv);
    case (sel)
      IDX_X:   return xv;
      IDX_Y:   return yv;
      default: return '0;
    endcase
  endfunction

  logic [DW-1:0] pre_v, post_v, base;
  logic [AW-1:0] word;

  always_comb begin
    pre_v  = pick(attr_o.pre, x_q, y_q);
    post_v = pick(attr_o.post, x_q, y_q);
    base   = byte_q[0] + pre_v;          // zero-page pointer wraps in DW bits
    case (step_i)
      2'd0:    rd_addr_o = pc_q;
      2'd1:    rd_addr_o = attr_o.ptr ? {ZERO_PG, base} : pc_q + AW'(1);
      default: rd_addr_o = {ZERO_PG, DW'(base + DW'(1))};
    endcase
    word      = attr_o.ptr ? {byte_q[2], byte_q[1]} : {byte_q[1], byte_q[0]};
    pc_next_o = pc_q + (attr_o.wide_pc ? AW'(2) : AW'(1));
    if (attr_o.rel)
      ea_o = pc_next_o + {{DW{byte_q[0][DW-1]}}, byte_q[0]};
    else if (attr_o.zp)
      ea_o = {ZERO_PG, DW'(byte_q[0] + post_v)};
    else
      ea_o = word + {ZERO_PG, post_v};
    operand_o = byte_q[0];
  end
endmodule

// File: rtl/addr_mode_seq.sv
module addr_mode_seq
  import aseq_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        mode_i,
  input  logic [2*DW-1:0]   pc_i,
  input  logic [DW-1:0]     x_i,
  input  logic [DW-1:0]     y_i,
  output logic              rd_req_o,
  output logic [2*DW-1:0]   rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DW-1:0]     rd_data_i,
  output logic              done_o,
  output logic              err_o,
  output logic              is_addr_o,
  output logic [DW-1:0]     operand_o,
  output logic [2*DW-1:0]   ea_o,
  output logic [2*DW-1:0]   pc_next_o
);
  attr_t             attr_q;
  logic              accept, cap;
  logic [STEP_W-1:0] step;

  aseq_ctl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .legal_i   (mode_legal(mode_i)),
    .last_i    (attr_q.last_step),
    .rd_valid_i(rd_valid_i),
    .rd_req_o  (rd_req_o),
    .done_o    (done_o),
    .accept_o  (accept),
    .cap_o     (cap),
    .step_o    (step)
  );

  aseq_dp #(.DW(DW)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .mode_i   (mode_i),
    .pc_i     (pc_i),
    .x_i      (x_i),
    .y_i      (y_i),
    .cap_i    (cap),
    .step_i   (step),
    .rd_data_i(rd_data_i),
    .attr_o   (attr_q),
    .rd_addr_o(rd_addr_o),
    .operand_o(operand_o),
    .ea_o     (ea_o),
    .pc_next_o(pc_next_o)
  );

  assign err_o     = done_o & ~attr_q.legal;
  assign is_addr_o = attr_q.is_addr;
endmodule

// File: rtl/aseq_sva.sv
module aseq_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic rd_req_o,
  input logic rd_valid_i,
  input logic done_o,
  input logic err_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else if (rd_req_o) pend_q <= 1'b1;
    else if (rd_valid_i) pend_q <= 1'b0;
  end

  a_r8_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  a_r8_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !pend_q);

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);

  a_r9_err_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r9_no_req_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o);
endmodule

bind addr_mode_seq aseq_sva u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .rd_req_o  (rd_req_o),
  .rd_valid_i(rd_valid_i),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/sim_addr_mode_seq.sv
module sim_addr_mode_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] pc = '0;
  logic [7:0]  xr = '0, yr = '0;
  logic        rd_req, done, err, is_addr;
  logic [15:0] rd_addr, ea, pc_next;
  logic [7:0]  operand;
  logic        vld_r = 1'b0, spur = 1'b0;
  logic [7:0]  dat_r = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;

  int total = 0, bad = 0, viol = 0, rd_total = 0;
  logic [15:0] rd_log [0:63];
  logic [15:0] cur_pc = '0;
  logic [7:0]  op_val = '0;
  bit          finished = 0;

  always #10 clk = ~clk;

  assign rd_valid = vld_r | spur;
  assign rd_data  = spur ? 8'hAA : dat_r;

  addr_mode_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .pc_i(pc),
    .x_i(xr), .y_i(yr), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .done_o(done), .err_o(err),
    .is_addr_o(is_addr), .operand_o(operand), .ea_o(ea), .pc_next_o(pc_next)
  );

  function automatic logic [7:0] memf(logic [15:0] a);
    logic [7:0] t;
    if (a == cur_pc) return op_val;
    t = a[7:0] * 8'd29;
    return (t ^ a[15:8]) + 8'h3b;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h (mode=%0d pc=%h x=%h y=%h op=%h)",
               req, what, act, exp, mode, pc, xr, yr, op_val);
    end
  endtask

  // memory responder: one reply per request, latency 1..3 cycles
  initial begin
    forever begin
      @(negedge clk);
      while (rst_n && rd_req) begin
        logic [15:0] a;
        int lat;
        a = rd_addr;
        lat = 1 + rd_total % 3;
        rd_log[rd_total % 64] = a;
        rd_total++;
        repeat (lat) begin
          @(negedge clk);
          if (rd_req) viol++;
        end
        dat_r = memf(a);
        vld_r = 1'b1;
        @(negedge clk);
        vld_r = 1'b0;
      end
    end
  end

  task automatic run(logic [3:0] m, logic [15:0] p, logic [7:0] xv, logic [7:0] yv,
                     logic [7:0] ov, bit inj);
    int base, n, nexp;
    logic [15:0] ex [3];
    logic [7:0]  b, lo, hi, idx;
    logic [15:0] eexp, pnexp;
    bit legal, isa;
    string tag;
    cur_pc = p; op_val = ov;
    mode = m; pc = p; xr = xv; yr = yv;
    start = 1'b1; spur = inj;   // stray reply on the accept edge (R11)
    base = rd_total;
    @(negedge clk);
    start = 1'b0; spur = 1'b0;
    n = 1;
    legal = (m < 4'd10);
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
      if (n == 3) begin start = 1'b0; mode = m; pc = p; xr = xv; yr = yv; end
      if (done) break;
      if (n == 2 && inj && legal) begin   // busy start, must be ignored (R10)
        start = 1'b1; mode = 4'd5; pc = 16'h0000; xr = 8'hff; yr = 8'hff;
      end
    end
    chk(done == 1'b1, "R9", "done reached", 32'(done), 1);
    b = memf(p); nexp = 1; ex[0] = p; ex[1] = '0; ex[2] = '0;
    pnexp = p + 16'd1; isa = 1; eexp = '0; tag = "R4";
    idx = (m == 4'd3 || m == 4'd6) ? xv : (m == 4'd4 || m == 4'd7) ? yv : 8'h00;
    case (m)
      4'd0: begin isa = 0; tag = "R2"; end
      4'd1: begin isa = 0; tag = "R3"; eexp = pnexp + {{8{b[7]}}, b}; end
      4'd2, 4'd3, 4'd4: begin tag = "R4"; eexp = {8'h00, 8'(b + idx)}; end
      4'd5, 4'd6, 4'd7: begin
        tag = "R5"; nexp = 2; ex[1] = p + 16'd1; pnexp = p + 16'd2;
        hi = memf(ex[1]); eexp = {hi, b} + {8'h00, idx};
      end
      4'd8: begin
        tag = "R6"; nexp = 3; lo = b + xv;
        ex[1] = {8'h00, lo}; ex[2] = {8'h00, 8'(lo + 8'd1)};
        eexp = {memf(ex[2]), memf(ex[1])};
      end
      4'd9: begin
        tag = "R7"; nexp = 3;
        ex[1] = {8'h00, b}; ex[2] = {8'h00, 8'(b + 8'd1)};
        eexp = {memf(ex[2]), memf(ex[1])} + {8'h00, yv};
      end
      default: nexp = 0;
    endcase
    if (!legal) begin
      chk(err == 1'b1, "R9", "err on undefined mode", 32'(err), 1);
      chk(rd_total == base, "R9", "no reads on undefined mode", 32'(rd_total - base), 0);
      chk(n == 1, "R9", "undefined mode latency", 32'(n), 1);
      return;
    end
    chk(err == 1'b0, "R9", "err low", 32'(err), 0);
    chk(rd_total - base == nexp, inj ? "R10" : tag, "read count", 32'(rd_total - base), 32'(nexp));
    for (int i = 0; i < 3; i++)
      if (i < nexp && i < rd_total - base)
        chk(rd_log[(base + i) % 64] == ex[i], tag, "read address",
            32'(rd_log[(base + i) % 64]), 32'(ex[i]));
    chk(operand == b, (m < 4'd2) ? "R2" : tag, "operand", 32'(operand), 32'(b));
    chk(pc_next == pnexp, tag, "pc_next", 32'(pc_next), 32'(pnexp));
    chk(is_addr == isa, tag, "is_addr", 32'(is_addr), 32'(isa));
    if (m != 4'd0)
      chk(ea == eexp, inj ? "R11" : tag, "ea", 32'(ea), 32'(eexp));
  endtask

  initial begin
    logic [7:0]  xs [4];
    logic [15:0] pcs [3];
    logic [7:0]  ops [5];
    xs[0] = 8'h00; xs[1] = 8'h01; xs[2] = 8'h80; xs[3] = 8'hff;
    pcs[0] = 16'h1234; pcs[1] = 16'h00ff; pcs[2] = 16'hffff;
    ops[0] = 8'h00; ops[1] = 8'h7f; ops[2] = 8'h80; ops[3] = 8'hfe; ops[4] = 8'hff;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1", "done after reset", 32'(done), 0);
    chk(err == 1'b0, "R1", "err after reset", 32'(err), 0);
    chk(rd_req == 1'b0, "R1", "rd_req after reset", 32'(rd_req), 0);
    // back-to-back launches: each run starts in the done cycle of the last (R10)
    for (int m = 0; m < 16; m++)
      for (int pi = 0; pi < 3; pi++) begin
        if (m >= 10) run(4'(m), pcs[pi], 8'h11, 8'h22, 8'h5a, 1'b0);
        else
          for (int xi = 0; xi < 4; xi++)
            for (int yi = 0; yi < 4; yi++)
              for (int oi = 0; oi < 5; oi++)
                run(4'(m), pcs[pi], xs[xi], xs[yi], ops[oi], (oi % 2) == 1);
      end
    repeat (6) @(negedge clk);
    chk(viol == 0, "R8", "request while reply pending", 32'(viol), 0);
    chk(done == 1'b0, "R9", "done idle after last run", 32'(done), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule